// File: doc/BRIEF.md
# I2C Slave-Receiver Status Engine

This block is the receive side of an I2C target. It watches the bus for START and STOP conditions and shifts in the first byte after each START. It accepts that byte when it carries the block's own 7-bit address with the write direction bit, or the general call address. After it has been selected, it receives the data bytes that follow. Each completed byte, and each bus event that ends a transfer, is reported to a host through an 8-bit status code and an interrupt flag.

The host controls acknowledgement with an enable input. If the enable is high when an address byte completes, the block acknowledges its own address (and, when general call is enabled, the general call address). For a data byte, the enable level sampled when the host last cleared the interrupt decides between ACK and NACK. While the interrupt flag is set after a ninth clock, the block stretches the bus by holding SCL low. A single flag input tells the block that its own master side has just lost arbitration, and the status code records this. A separate pulse input reports a bus-reset event with its own code.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset `si` is 0, `status` is 0xF8 and neither `sda_oe` nor `scl_oe` is asserted.
- R2: The address byte is {address[6:0], direction}, MSB first. If it equals {own_addr, 0} and `ack_en` is 1 at the eighth bit, the block ACKs it and sets `si`. `status` becomes 0x60 when `arb_lost` is 0 and 0x68 when it is 1.
- R3: An address byte of 0x00 is ACKed only when both `gc_en` and `ack_en` are 1. `status` becomes 0x70, or 0x78 with `arb_lost` high. With `gc_en` at 0 the byte is ignored: no ACK and no `si`.
- R4: The block gives no ACK and leaves `si` unchanged when the address differs, when the direction bit is 1, or when `ack_en` is 0.
- R5: After own-address selection, a data byte is ACKed when `ack_en` was 1 at the last `si_clr`. `status` becomes 0x80 and `rx_data` holds the byte.
- R6: If `ack_en` was 0 at the last `si_clr`, the data byte is NACKed and `status` becomes 0x88. The block then ignores the bus (no ACK, no `si`) until the next START.
- R7: After general-call selection, data bytes report 0x90 when ACKed and 0x98 when NACKed.
- R8: A STOP or repeated START seen while the block is selected and `si` is 0 sets `si` with `status` 0xA0. A STOP seen while the block is not selected changes nothing.
- R9: From the falling edge of the ninth clock of an accepted byte until `si_clr`, `scl_oe` is 1. `scl_oe` is never 1 while `si` is 0.
- R10: A pulse on `smb_reset` sets `si` with `status` 0xD0, deselects the block and releases both lines.
- R11: Pulsing `si_clr` while `si` is 1 clears `si` and sets `status` to 0xF8 on the next cycle.
- R12: `sda_oe` is asserted only for the ACK bit: from the falling edge after the eighth data bit to the falling edge after the ninth. It never changes while SCL is high, except on `smb_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL bus level, synchronous to clk |
| sda_i | input | 1 | Sampled SDA bus level, synchronous to clk |
| own_addr | input | 7 | The block's own 7-bit address |
| ack_en | input | 1 | Host acknowledge enable |
| gc_en | input | 1 | Enables general call recognition |
| arb_lost | input | 1 | Master side lost arbitration in its address phase |
| smb_reset | input | 1 | One-cycle bus-reset event pulse |
| si_clr | input | 1 | One-cycle pulse that clears the interrupt flag |
| sda_oe | output | 1 | Pull SDA low (ACK drive) |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| si | output | 1 | Interrupt flag |
| status | output | 8 | Status code of the last event |
| rx_data | output | 8 | Last received data byte |

## Verification
The assertions rely on a few properties of the inputs. SCL and SDA are already synchronous to `clk`, and each level is held for at least two clock cycles. The master never moves SCL while the block stretches it. `si_clr` never lands in the same cycle as an SCL edge or a START/STOP. The bench drives the bus from a master model that changes lines only on falling `clk` edges and holds every level for two or more cycles. It pulses `si_clr` only while SCL is held low or the bus is idle. It resolves both lines as a wired-AND of the master's levels and the block's pull-downs, so the ACK and stretch appear on the bus levels that the block samples.

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] own_addr,
  input  logic       ack_en,
  input  logic       gc_en,
  input  logic       arb_lost,
  input  logic       smb_reset,
  input  logic       si_clr,
  output logic       sda_oe,
  output logic       scl_oe,
  output logic       si,
  output logic [7:0] status,
  output logic [7:0] rx_data
);
  localparam logic [7:0] ST_IDLE = 8'hF8;
  localparam logic [7:0] ST_END  = 8'hA0;
  localparam logic [7:0] ST_BRST = 8'hD0;

  logic       scl_q, sda_q;
  logic       active, selected, gcall, ack_next;
  logic [3:0] bitcnt;
  logic [7:0] shreg;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire own_hit  = (shreg[7:1] == own_addr) & ~shreg[0] & ack_en;
  wire gc_hit   = (shreg == 8'h00) & gc_en & ack_en;

  wire [7:0] addr_code = gcall ? (arb_lost ? 8'h78 : 8'h70) : (arb_lost ? 8'h68 : 8'h60);
  wire [7:0] data_code = gcall ? (sda_oe ? 8'h90 : 8'h98) : (sda_oe ? 8'h80 : 8'h88);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      active   <= 1'b0;
      selected <= 1'b0;
      gcall    <= 1'b0;
      ack_next <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      scl_oe   <= 1'b0;
      si       <= 1'b0;
      status   <= ST_IDLE;
      rx_data  <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (smb_reset) begin
        si       <= 1'b1;
        status   <= ST_BRST;
        selected <= 1'b0;
        active   <= 1'b0;
        sda_oe   <= 1'b0;
        scl_oe   <= 1'b0;
      end else begin
        if (start_c) begin
          active   <= 1'b1;
          bitcnt   <= '0;
          sda_oe   <= 1'b0;
          selected <= 1'b0;
          gcall    <= 1'b0;
          if (selected && !si) begin
            si     <= 1'b1;
            status <= ST_END;
          end
        end else if (stop_c) begin
          active   <= 1'b0;
          sda_oe   <= 1'b0;
          selected <= 1'b0;
          gcall    <= 1'b0;
          if (selected && !si) begin
            si     <= 1'b1;
            status <= ST_END;
          end
        end else if (active && scl_rise) begin
          if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_i};
          bitcnt <= bitcnt + 4'd1;
        end else if (active && scl_fall) begin
          if (bitcnt == 4'd8) begin
            if (!selected) begin
              if (own_hit || gc_hit) begin
                sda_oe <= 1'b1;
                gcall  <= gc_hit;
              end else begin
                active <= 1'b0;
              end
            end else begin
              sda_oe <= ack_next;
            end
          end else if (bitcnt == 4'd9) begin
            sda_oe <= 1'b0;
            si     <= 1'b1;
            scl_oe <= 1'b1;
            active <= 1'b0;
            bitcnt <= '0;
            if (!selected) begin
              selected <= 1'b1;
              status   <= addr_code;
            end else begin
              rx_data <= shreg;
              status  <= data_code;
              if (!sda_oe) selected <= 1'b0;
            end
          end
        end
        if (si_clr && si) begin
          si       <= 1'b0;
          scl_oe   <= 1'b0;
          status   <= ST_IDLE;
          ack_next <= ack_en;
          if (selected) begin
            active <= 1'b1;
            bitcnt <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       smb_reset,
  input logic       si_clr,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       si,
  input logic [7:0] status
);
  AST_ACK_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(smb_reset)) |-> !$past(scl_i)); // R12

  AST_STRETCH_NEEDS_SI: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> si); // R9

  AST_STRETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (status inside {8'h60, 8'h68, 8'h70, 8'h78, 8'h80, 8'h88, 8'h90, 8'h98})); // R2

  AST_BUS_RESET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smb_reset) |-> (si && status == 8'hD0 && !scl_oe && !sda_oe)); // R10

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(si_clr && si && !smb_reset) |-> (!si && status == 8'hF8)); // R11
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .smb_reset(smb_reset), .si_clr(si_clr),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .si(si), .status(status)
);

// File: tb/test_i2c_slave_rx.sv
module test_i2c_slave_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic ack_en = 1'b1, gc_en = 1'b0, arb_lost = 1'b0, smb_reset = 1'b0, si_clr = 1'b0;
  logic sda_oe, scl_oe, si;
  logic [7:0] status, rx_data;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic finished = 1'b0;

  localparam logic [6:0] OWN = 7'h2C;

  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_slave_rx i_i2c_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .own_addr(OWN),
    .ack_en(ack_en), .gc_en(gc_en), .arb_lost(arb_lost), .smb_reset(smb_reset),
    .si_clr(si_clr), .sda_oe(sda_oe), .scl_oe(scl_oe), .si(si), .status(status),
    .rx_data(rx_data)
  );

  // {address byte, ack_en, gc_en, arb_lost, expected ack, expected status}
  localparam logic [19:0] VEC [8] = '{
    {8'h58, 1'b1, 1'b0, 1'b0, 1'b1, 8'h60},
    {8'h58, 1'b1, 1'b0, 1'b1, 1'b1, 8'h68},
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h70},
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h78},
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hF8},
    {8'h58, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF8},
    {8'h59, 1'b1, 1'b0, 1'b0, 1'b0, 8'hF8},
    {8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF8}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; idle(2);
    m_scl = 1'b1; idle(4);
    m_sda = 1'b0; idle(4);
    m_scl = 1'b0; idle(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; idle(2);
    m_scl = 1'b1; idle(4);
    m_sda = 1'b1; idle(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic early);
    early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; idle(2);
      m_scl = 1'b1; idle(2);
      if (sda_oe) early = 1'b1;
      idle(2);
      m_scl = 1'b0; idle(2);
    end
    m_sda = 1'b1; idle(2);
    m_scl = 1'b1; idle(2);
    ack = ~sda_bus;
    idle(2);
    m_scl = 1'b0; idle(4);
  endtask

  task automatic clear_si();
    si_clr = 1'b1; idle(1);
    si_clr = 1'b0; idle(2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  initial begin
    logic a, e;
    idle(3);
    chk("R1 si", {7'd0, si}, 8'h00);
    chk("R1 status", status, 8'hF8);
    chk("R1 drives", {6'd0, sda_oe, scl_oe}, 8'h00);
    rst_n = 1'b1; idle(4);

    for (int k = 0; k < 8; k++) begin
      logic [19:0] v;
      v = VEC[k];
      ack_en = v[11]; gc_en = v[10]; arb_lost = v[9];
      bus_start();
      send_byte(v[19:12], a, e);
      chk("R12 no drive in data bits", {7'd0, e}, 8'h00);
      chk(v[8] ? "R2/R3 address ack" : "R4 address ignored", {7'd0, a}, {7'd0, v[8]});
      chk("R2/R3/R4 si", {7'd0, si}, {7'd0, v[8]});
      chk("R2/R3/R4 status", status, v[7:0]);
      if (v[8]) begin
        chk("R9 stretch", {7'd0, scl_oe}, 8'h01);
        clear_si();
        chk("R11 cleared", {si, 7'd0} | {7'd0, scl_oe}, 8'h00);
        chk("R11 status", status, 8'hF8);
        bus_stop();
        chk("R8 stop selected", {7'd0, si}, 8'h01);
        chk("R8 status", status, 8'hA0);
        clear_si();
      end else begin
        bus_stop();
        chk("R8 stop unselected", {7'd0, si}, 8'h00);
        chk("R8 status", status, 8'hF8);
      end
    end
    arb_lost = 1'b0; gc_en = 1'b0; ack_en = 1'b1;

    // own-address data: ACK then NACK, then released
    bus_start();
    send_byte(8'h58, a, e);
    clear_si();
    send_byte(8'hA5, a, e);
    chk("R5 ack", {7'd0, a}, 8'h01);
    chk("R5 status", status, 8'h80);
    chk("R5 rx_data", rx_data, 8'hA5);
    chk("R12 no drive in data bits", {7'd0, e}, 8'h00);
    ack_en = 1'b0;
    clear_si();
    ack_en = 1'b1;
    send_byte(8'h3C, a, e);
    chk("R6 nack", {7'd0, a}, 8'h00);
    chk("R6 status", status, 8'h88);
    chk("R6 rx_data", rx_data, 8'h3C);
    clear_si();
    send_byte(8'hFF, a, e);
    chk("R6 released ack", {7'd0, a}, 8'h00);
    chk("R6 released si", {7'd0, si}, 8'h00);
    bus_stop();
    chk("R8 stop after release", {7'd0, si}, 8'h00);

    // general call data
    gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, a, e);
    chk("R3 gc status", status, 8'h70);
    clear_si();
    send_byte(8'h11, a, e);
    chk("R7 gc ack", {7'd0, a}, 8'h01);
    chk("R7 gc status ack", status, 8'h90);
    ack_en = 1'b0;
    clear_si();
    ack_en = 1'b1;
    send_byte(8'h22, a, e);
    chk("R7 gc status nack", status, 8'h98);
    clear_si();
    bus_stop();
    gc_en = 1'b0;

    // repeated start while selected
    bus_start();
    send_byte(8'h58, a, e);
    clear_si();
    send_byte(8'h01, a, e);
    chk("R5 status", status, 8'h80);
    clear_si();
    bus_start();
    chk("R8 restart si", {7'd0, si}, 8'h01);
    chk("R8 restart status", status, 8'hA0);
    clear_si();
    send_byte(8'h58, a, e);
    chk("R2 reselect ack", {7'd0, a}, 8'h01);
    chk("R2 reselect status", status, 8'h60);
    clear_si();
    bus_stop();
    chk("R8 final stop", status, 8'hA0);
    clear_si();

    // bus reset event
    smb_reset = 1'b1; idle(1);
    smb_reset = 1'b0; idle(2);
    chk("R10 si", {7'd0, si}, 8'h01);
    chk("R10 status", status, 8'hD0);
    clear_si();
    chk("R11 after bus reset", status, 8'hF8);

    // reset in the middle of a stretched transfer
    bus_start();
    send_byte(8'h58, a, e);
    chk("R9 stretch before reset", {7'd0, scl_oe}, 8'h01);
    rst_n = 1'b0; idle(2);
    chk("R1 reset si", {7'd0, si}, 8'h00);
    chk("R1 reset status", status, 8'hF8);
    chk("R1 reset drives", {6'd0, sda_oe, scl_oe}, 8'h00);
    rst_n = 1'b1;
    bus_stop();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule